// File: doc/BRIEF.md
# Interrupt pin service and delivery engine

This block sits between a set of interrupt input pins and the message fabric that carries interrupts to processor-local controllers. Each pin owns a redirection entry that software loads through a simple write port; the entry names the vector, destination, destination mode, delivery mode, trigger mode and input polarity, and carries a mask bit. The engine tracks a per-pin request bit from the polarity-corrected pin level and decides when a pin is serviced. It then issues one delivery message per valid/ready handshake, taking the lowest-numbered pin first.

Edge-triggered pins produce one message for each rising effective edge. Level-triggered pins are gated by a per-pin in-service flag. A delivery sets the flag, and only a level-type end of interrupt whose vector matches the entry clears it. A request that arrives while a pin is still blocked is reported as coalesced rather than delivered. Per-pin pulse outputs tell the surrounding logic which outcome each request had.

Top module: `pin_svc_engine`

## Requirements
- R1: After reset every entry is masked with all other fields zero, msgValid is low and no delivered or coalesced pulse is active.
- R2: Entry word layout (entWrData): vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 12, trigger mode in 13 (1 = level), mask in 14 (1 = masked), destination in 22:15. A message carries the serviced entry's vector, destination, destination mode, trigger mode and delivery mode.
- R3: A pin's effective level is its input XOR the entry's polarity bit. With polarity 1, the active input level is low.
- R4: An unmasked edge-triggered pin requests exactly one message for each rising effective edge. A falling edge requests none.
- R5: An unmasked level-triggered pin requests a message while its effective level is high and its in-service flag is clear. The handshake sets the flag, and no further message follows from that pin while the flag is set.
- R6: A rising effective edge on an unmasked pin produces a one-cycle coalescedPulse for that pin, with no extra message, when the pin is level-triggered with its in-service flag set, or edge-triggered with a message still waiting.
- R7: A masked pin issues no message and no coalesced pulse.
- R8: An end of interrupt with eoiLevel=1 clears the in-service flag of every entry whose vector equals eoiVector. An unmasked entry whose effective level is still high then requests again on the next cycle.
- R9: An end of interrupt with eoiLevel=0, or one whose vector appears in no entry, changes nothing.
- R10: Writing an entry clears that pin's in-service flag and any waiting edge request. A level-triggered pin whose effective level is high is serviced right after the write.
- R11: When several pins request, the lowest-numbered pin is offered first. Each handshake (msgValid and msgReady high at a clock edge) consumes exactly one message.
- R12: deliveredPulse has at most one bit set. The set bit marks the pin whose message is handshaken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | NUM_PINS | Raw interrupt input levels |
| entWrEn | input | 1 | Redirection entry write strobe |
| entWrIdx | input | IDX_W | Pin whose entry is written |
| entWrData | input | 23 | New entry word (layout in R2) |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector being acknowledged |
| eoiLevel | input | 1 | 1 = level-type acknowledgement |
| msgValid | output | 1 | A delivery message is offered |
| msgReady | input | 1 | Receiver accepts the message |
| msgDest | output | 8 | Destination of the message |
| msgVector | output | 8 | Vector of the message |
| msgDestMode | output | 1 | Destination mode of the message |
| msgTrigLevel | output | 1 | Trigger mode of the message (1 = level) |
| msgDelivMode | output | 3 | Delivery mode of the message |
| deliveredPulse | output | NUM_PINS | Pin whose message is handshaken this cycle |
| coalescedPulse | output | NUM_PINS | Pin whose new request was coalesced this cycle |

## Verification
The assertions assume that the receiver may hold msgReady low for any number of cycles. The message-hold property is only claimed for cycles in which the pins, the entry table and the end-of-interrupt input are quiet, because a level pin may legally withdraw its request. The stimulus changes pin levels only between clock edges and never writes an entry and acknowledges it in the same cycle. It keeps every active pin on a distinct vector, so each acknowledgement reaches exactly the pin the bench intends.

// File: rtl/pin_svc_pkg.sv
package pin_svc_pkg;
  localparam int VEC_W     = 8;
  localparam int DEST_W    = 8;
  localparam int DLV_W     = 3;
  localparam int SEL_MAX_W = 8;
  localparam int NUM_VEC   = 1 << VEC_W;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trigLevel;
    logic              polarity;
    logic              destMode;
    logic [DLV_W-1:0]  delivMode;
    logic [VEC_W-1:0]  vector;
  } redirEntry_t;

  localparam int ENTRY_W = $bits(redirEntry_t);
  localparam redirEntry_t RESET_ENTRY = '{mask: 1'b1, default: '0};

  // control-to-datapath strobes
  typedef struct packed {
    logic                 fire;
    logic [SEL_MAX_W-1:0] selIdx;
  } svcStrobe_t;
endpackage

// File: rtl/pin_svc_table.sv
module pin_svc_table
  import pin_svc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                entWrEn,
  input  logic [IDX_W-1:0]    entWrIdx,
  input  logic [ENTRY_W-1:0]  entWrData,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  input  logic                eoiLevel,
  input  svcStrobe_t          strobe,
  output logic [NUM_PINS-1:0] maskVec,
  output logic [NUM_PINS-1:0] trigVec,
  output logic [NUM_PINS-1:0] polVec,
  output logic [NUM_PINS-1:0] eoiClr,
  output logic [DEST_W-1:0]   msgDest,
  output logic [VEC_W-1:0]    msgVector,
  output logic                msgDestMode,
  output logic                msgTrigLevel,
  output logic [DLV_W-1:0]    msgDelivMode
);
  redirEntry_t entQ [NUM_PINS];
  redirEntry_t entNext [NUM_PINS];
  logic [NUM_VEC-1:0] handledQ, handledNext;
  logic eoiHit;
  redirEntry_t selEnt;
  logic unusedStrobe;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) entNext[i] = entQ[i];
    if (entWrEn && (32'(entWrIdx) < NUM_PINS)) entNext[entWrIdx] = redirEntry_t'(entWrData);
    handledNext = '0;
    for (int i = 0; i < NUM_PINS; i++) handledNext[entNext[i].vector] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) entQ[i] <= RESET_ENTRY;
      handledQ    <= '0;
      handledQ[0] <= 1'b1;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) entQ[i] <= entNext[i];
      handledQ <= handledNext;
    end
  end

  assign eoiHit = eoiValid && eoiLevel && handledQ[eoiVector];

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPinCfg
    assign maskVec[g] = entQ[g].mask;
    assign trigVec[g] = entQ[g].trigLevel;
    assign polVec[g]  = entQ[g].polarity;
    assign eoiClr[g]  = eoiHit && (entQ[g].vector == eoiVector);
  end

  assign selEnt       = entQ[strobe.selIdx[IDX_W-1:0]];
  assign msgDest      = selEnt.dest;
  assign msgVector    = selEnt.vector;
  assign msgDestMode  = selEnt.destMode;
  assign msgTrigLevel = selEnt.trigLevel;
  assign msgDelivMode = selEnt.delivMode;
  assign unusedStrobe = ^{strobe.fire, strobe.selIdx};
endmodule

// File: rtl/pin_svc_ctrl.sv
module pin_svc_ctrl
  import pin_svc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] maskVec,
  input  logic [NUM_PINS-1:0] trigVec,
  input  logic [NUM_PINS-1:0] polVec,
  input  logic [NUM_PINS-1:0] eoiClr,
  input  logic                entWrEn,
  input  logic [IDX_W-1:0]    entWrIdx,
  input  logic                msgReady,
  output logic                msgValid,
  output svcStrobe_t          strobe,
  output logic [NUM_PINS-1:0] deliveredPulse,
  output logic [NUM_PINS-1:0] coalescedPulse
);
  logic [NUM_PINS-1:0] irrQ, remoteQ, edgePendQ;
  logic [NUM_PINS-1:0] remoteD, edgePendD;
  logic [NUM_PINS-1:0] effLevel, rise, req, grant, wrHit;
  logic [IDX_W-1:0]    selIdx;
  logic                fire;

  assign effLevel = pinLevel ^ polVec;
  assign rise     = effLevel & ~irrQ;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPinReq
    assign wrHit[g] = entWrEn && (32'(entWrIdx) == g);
    assign req[g]   = !maskVec[g] &&
                      (trigVec[g] ? (irrQ[g] && !remoteQ[g]) : edgePendQ[g]);
    assign coalescedPulse[g] = rise[g] && !maskVec[g] &&
                      (trigVec[g] ? remoteQ[g] : (edgePendQ[g] && !grant[g]));
  end

  // lowest-numbered requester wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) if (req[i]) selIdx = IDX_W'(i);
  end

  assign msgValid       = |req;
  assign fire           = msgValid && msgReady;
  assign grant          = fire ? (NUM_PINS'(1) << selIdx) : '0;
  assign deliveredPulse = grant;
  assign strobe.fire    = fire;
  assign strobe.selIdx  = SEL_MAX_W'(selIdx);

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (wrHit[i])                    remoteD[i] = 1'b0;
      else if (grant[i] && trigVec[i]) remoteD[i] = 1'b1;
      else if (eoiClr[i])              remoteD[i] = 1'b0;
      else                             remoteD[i] = remoteQ[i];

      if (wrHit[i])                                      edgePendD[i] = 1'b0;
      else if (rise[i] && !trigVec[i] && !maskVec[i])   edgePendD[i] = 1'b1;
      else if (grant[i])                                 edgePendD[i] = 1'b0;
      else                                               edgePendD[i] = edgePendQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ      <= '0;
      remoteQ   <= '0;
      edgePendQ <= '0;
    end else begin
      irrQ      <= effLevel;
      remoteQ   <= remoteD;
      edgePendQ <= edgePendD;
    end
  end
endmodule

// File: rtl/pin_svc_engine.sv
module pin_svc_engine
  import pin_svc_pkg::*;
#(
  parameter int  NUM_PINS = 8,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic                entWrEn,
  input  logic [IDX_W-1:0]    entWrIdx,
  input  logic [ENTRY_W-1:0]  entWrData,
  input  logic                eoiValid,
  input  logic [VEC_W-1:0]    eoiVector,
  input  logic                eoiLevel,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [DEST_W-1:0]   msgDest,
  output logic [VEC_W-1:0]    msgVector,
  output logic                msgDestMode,
  output logic                msgTrigLevel,
  output logic [DLV_W-1:0]    msgDelivMode,
  output logic [NUM_PINS-1:0] deliveredPulse,
  output logic [NUM_PINS-1:0] coalescedPulse
);
  svcStrobe_t          strobe;
  logic [NUM_PINS-1:0] maskVec, trigVec, polVec, eoiClr;

  pin_svc_ctrl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) ctrl (
    .clk, .rstN, .pinLevel, .maskVec, .trigVec, .polVec, .eoiClr,
    .entWrEn, .entWrIdx, .msgReady, .msgValid, .strobe,
    .deliveredPulse, .coalescedPulse
  );

  pin_svc_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) table_i (
    .clk, .rstN, .entWrEn, .entWrIdx, .entWrData, .eoiValid, .eoiVector,
    .eoiLevel, .strobe, .maskVec, .trigVec, .polVec, .eoiClr,
    .msgDest, .msgVector, .msgDestMode, .msgTrigLevel, .msgDelivMode
  );
endmodule

// File: rtl/pin_svc_engine_chk.sv
module pin_svc_engine_chk
  import pin_svc_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic                entWrEn,
  input logic                eoiValid,
  input logic                msgValid,
  input logic                msgReady,
  input logic [VEC_W-1:0]    msgVector,
  input logic                msgTrigLevel,
  input logic [NUM_PINS-1:0] deliveredPulse,
  input logic [NUM_PINS-1:0] coalescedPulse
);
  // R12
  delivered_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(deliveredPulse));

  // R12
  delivered_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deliveredPulse != '0) == (msgValid && msgReady));

  // R6
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deliveredPulse & coalescedPulse) == '0);

  // R5
  level_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deliveredPulse != '0) && msgTrigLevel && !entWrEn
    |=> (deliveredPulse & $past(deliveredPulse)) == '0);

  // R11
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady && !entWrEn && !eoiValid && $stable(pinLevel) && !$past(entWrEn)
    |=> msgValid && $stable(msgVector));
endmodule

bind pin_svc_engine pin_svc_engine_chk #(.NUM_PINS(NUM_PINS)) chkInst (.*);

// File: tb/pin_svc_engine_test.sv
`timescale 1ns/1ps
module pin_svc_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pins = '0;
  logic        entWrEn = 1'b0;
  logic [2:0]  entWrIdx = '0;
  logic [22:0] entWrData = '0;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;
  logic        eoiLevel = 1'b0;
  logic        msgValid, msgReady = 1'b0;
  logic [7:0]  msgDest, msgVector;
  logic        msgDestMode, msgTrigLevel;
  logic [2:0]  msgDelivMode;
  logic [7:0]  deliveredPulse, coalescedPulse;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_svc_engine #(.NUM_PINS(8)) uut (
    .clk, .rstN, .pinLevel(pins), .entWrEn, .entWrIdx, .entWrData,
    .eoiValid, .eoiVector, .eoiLevel, .msgValid, .msgReady, .msgDest,
    .msgVector, .msgDestMode, .msgTrigLevel, .msgDelivMode,
    .deliveredPulse, .coalescedPulse
  );

  // row: {idx[2:0], trig, pol, vector[7:0], dest[7:0], destMode, deliv[2:0]}
  localparam logic [24:0] TBL [4] = '{
    {3'd2, 1'b0, 1'b0, 8'h31, 8'h05, 1'b0, 3'd0},
    {3'd5, 1'b1, 1'b0, 8'h42, 8'h0A, 1'b1, 3'd1},
    {3'd0, 1'b0, 1'b1, 8'h53, 8'h0F, 1'b0, 3'd4},
    {3'd7, 1'b1, 1'b1, 8'h64, 8'hA0, 1'b1, 3'd7}
  };

  function automatic logic [22:0] mkEnt(input logic [7:0] dest, input logic m, tl, pol, dm,
                                        input logic [2:0] dlv, input logic [7:0] vec);
    return {dest, m, tl, pol, dm, dlv, vec};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrEnt(input logic [2:0] idx, input logic [22:0] data);
    entWrIdx = idx; entWrData = data; entWrEn = 1'b1;
    cyc();
    entWrEn = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] vec, input logic lvl);
    eoiVector = vec; eoiLevel = lvl; eoiValid = 1'b1;
    cyc();
    eoiValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    #1;
    chk("R1 valid in reset", msgValid, 0);
    rstN = 1'b1;
    cyc(); #1;
    chk("R1 valid after reset", msgValid, 0);
    chk("R1 delivered after reset", deliveredPulse, 0);
    chk("R1 coalesced after reset", coalescedPulse, 0);

    // table walk: R2 fields, R3 polarity, R4/R5 single delivery
    foreach (TBL[r]) begin
      logic [2:0] idx; logic tl, pol, dm; logic [7:0] vec, dst; logic [2:0] dlv;
      {idx, tl, pol, vec, dst, dm, dlv} = TBL[r];
      pins[idx] = pol;
      cyc();
      wrEnt(idx, mkEnt(dst, 1'b0, tl, pol, dm, dlv, vec));
      cyc(); #1;
      chk("R3 inactive level idle", msgValid, 0);
      pins[idx] = ~pol;
      cyc(); #1;
      chk("R3 active level requests", msgValid, 1);
      chk("R2 vector", msgVector, vec);
      chk("R2 dest", msgDest, dst);
      chk("R2 destMode", msgDestMode, dm);
      chk("R2 trig", msgTrigLevel, tl);
      chk("R2 deliv", msgDelivMode, dlv);
      chk("R12 no pulse without ready", deliveredPulse, 0);
      msgReady = 1'b1; #1;
      chk("R12 pulse on handshake", deliveredPulse, 32'(8'(1) << idx));
      cyc();
      msgReady = 1'b0; #1;
      chk(tl ? "R5 level blocked after delivery" : "R4 edge single message", msgValid, 0);
      pins[idx] = pol;
      if (tl) eoi(vec, 1'b1); else cyc();
      wrEnt(idx, mkEnt(dst, 1'b1, tl, pol, dm, dlv, vec));
      #1;
      chk("R7 masked after cleanup", msgValid, 0);
    end

    // level pin 3: remote flag, coalescing, EOI handling
    pins[3] = 1'b0;
    wrEnt(3'd3, mkEnt(8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h70));
    cyc();
    pins[3] = 1'b1;
    cyc(); #1;
    chk("R5 level request", msgValid, 1);
    chk("R5 level vector", msgVector, 8'h70);
    msgReady = 1'b1;
    cyc();
    msgReady = 1'b0; #1;
    chk("R5 remote blocks", msgValid, 0);
    pins[3] = 1'b0;
    cyc();
    pins[3] = 1'b1; #1;
    chk("R6 level coalesced", coalescedPulse, 8'h08);
    cyc(); #1;
    chk("R6 no message on coalesce", msgValid, 0);
    eoi(8'h70, 1'b0); #1;
    chk("R9 edge-type eoi ignored", msgValid, 0);
    eoi(8'h71, 1'b1); #1;
    chk("R9 absent vector eoi ignored", msgValid, 0);
    eoi(8'h70, 1'b1); #1;
    chk("R8 redelivery after eoi", msgValid, 1);
    chk("R8 redelivery vector", msgVector, 8'h70);
    msgReady = 1'b1; #1;
    chk("R8 redelivered pulse", deliveredPulse, 8'h08);
    cyc();
    msgReady = 1'b0;
    pins[3] = 1'b0;
    eoi(8'h70, 1'b1); #1;
    chk("R8 no redelivery when input low", msgValid, 0);
    wrEnt(3'd3, mkEnt(8'h33, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h70));

    // priority between pins 1 and 6 (edge)
    wrEnt(3'd1, mkEnt(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h11));
    wrEnt(3'd6, mkEnt(8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h16));
    pins[1] = 1'b1; pins[6] = 1'b1;
    cyc(); #1;
    chk("R11 lowest pin first", msgVector, 8'h11);
    msgReady = 1'b1; #1;
    chk("R12 pulse pin1", deliveredPulse, 8'h02);
    cyc(); #1;
    chk("R11 next pin after handshake", msgVector, 8'h16);
    chk("R12 pulse pin6", deliveredPulse, 8'h40);
    cyc();
    msgReady = 1'b0; #1;
    chk("R4 one message per edge", msgValid, 0);

    // edge coalescing and falling edges on pin 1
    pins[1] = 1'b0;
    cyc(); #1;
    chk("R4 falling edge no message", msgValid, 0);
    pins[1] = 1'b1;
    cyc(); #1;
    chk("R4 rising edge request", msgValid, 1);
    pins[1] = 1'b0;
    cyc();
    pins[1] = 1'b1; #1;
    chk("R6 edge coalesced", coalescedPulse, 8'h02);
    cyc();
    msgReady = 1'b1; #1;
    chk("R12 single edge delivery", deliveredPulse, 8'h02);
    cyc();
    msgReady = 1'b0; #1;
    chk("R6 coalesced edge not resent", msgValid, 0);

    // masked pin 4, then service on entry write
    pins[4] = 1'b1;
    cyc(); cyc(); #1;
    chk("R7 masked no message", msgValid, 0);
    chk("R7 masked no coalesce", coalescedPulse, 0);
    wrEnt(3'd4, mkEnt(8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 8'h44)); #1;
    chk("R10 write services level pin", msgValid, 1);
    chk("R10 vector", msgVector, 8'h44);
    msgReady = 1'b1;
    cyc();
    msgReady = 1'b0; #1;
    chk("R5 blocked after delivery", msgValid, 0);
    wrEnt(3'd4, mkEnt(8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 8'h44)); #1;
    chk("R10 rewrite clears in-service", msgValid, 1);
    wrEnt(3'd4, mkEnt(8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 8'h44)); #1;
    chk("R7 mask withdraws request", msgValid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule